// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns a 21-bit parallel pixel word into three serial data lanes and one forwarded-clock lane. Each word holds 18 colour bits and three timing controls (line sync, frame sync, data enable). One word is taken per pixel clock. The logic runs on a bit clock, supplied by the integrating logic, at seven times the pixel rate. Each data lane therefore emits seven bits per pixel period. The fourth lane carries a fixed seven-slot pattern that marks the word boundary for the receiver.

An `edge_sel` pin picks the pixel-clock edge on which the input word is captured. An active-low power-down input clears all internal state and drives every output to 0. After each release from power-down, a lock timer counts a parameterised number of bit clocks before the output enable rises. The enable always rises at the first slot of a word. The captured word crosses into the bit-clock domain through a hold register and is then copied into the lane shifters. Each copy happens exactly once per pixel period, so a word is never torn.

Top module: `lvds7_serializer`

## Requirements
- R1: Bits 0–6 of the word go out on `lane_out[0]`, bits 7–13 on `lane_out[1]` and bits 14–20 on `lane_out[2]`. Within each lane the lowest-numbered bit goes out in slot 0 and the highest in slot 6. Every word presented to the block appears on the lanes intact and in the order it was presented.
- R2: Each lane emits one bit per bit clock, which is seven bits per pixel period.
- R3: A new word enters the lane shifters exactly once every 7 bit-clock cycles while the pixel clock runs.
- R4: With `edge_sel` = 1 the word is captured on the rising pixel-clock edge. With `edge_sel` = 0 it is captured on the falling edge. The value present at the other edge has no effect.
- R5: While enabled, the forwarded-clock lane sends levels 1,1,0,0,0,1,1 in slots 0 through 6 of every word. Its falling edge therefore falls between slot 1 and slot 2.
- R6: When `pwr_dn_n` is sampled low, `out_en` and all lane outputs are 0 from the next bit clock onward, and internal state is cleared.
- R7: After release, `out_en` stays low for at least LOCK_CYCLES+1 bit clocks and rises no later than LOCK_CYCLES+7 bit clocks. It rises with slot 0 on the lanes.
- R8: Whenever `out_en` is low, every lane output, the clock lane included, is 0.
- R9: Every release from power-down restarts the lock interval from zero, including a release that follows a power-down issued in the middle of a lock interval.
- R10: Synchronous `rst` acts like power-down: `out_en` and all outputs read 0 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Bit clock, 7x pixel rate |
| pix_clk | input | 1 | Pixel clock |
| pix_data | input | 21 | Pixel word: colour and timing controls |
| edge_sel | input | 1 | 1 = capture on rising edge, 0 = falling |
| pwr_dn_n | input | 1 | Active-low power-down |
| lane_out | output | 3 | Serial data lanes |
| clk_lane_out | output | 1 | Forwarded-clock lane |
| out_en | output | 1 | Output enable (drivers active) |

## Verification
The bench holds the pixel word stable only around the selected edge and places its complement at the other edge. A design that captures on the wrong edge therefore sends complemented words, and the scoreboard loses the stream. Each received word is rebuilt by locking onto the falling edge of the forwarded-clock lane. Any swap of lanes or of bit order within a lane, or a misplaced clock pattern, breaks that rebuild. The lock interval is timed after a clean release, and again after a power-down issued halfway through a lock. A timer that does not restart would raise the enable too early on the second release. A design that leaves outputs active or non-zero during power-down is caught by the per-cycle quiet check.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;
  // Forwarded-clock lane level for a given slot: low in the middle three slots
  // of a 7-slot word, high in the two slots on each side of them.
  function automatic logic fwd_clk_level(input int unsigned slot, input int unsigned slots);
    return (slot < 2) || (slot >= slots - 2);
  endfunction
endpackage

// File: rtl/lvds7_capture.sv
module lvds7_capture #(
  parameter int WORD_W = 21
) (
  input  logic              bit_clk,
  input  logic              clr,
  input  logic              pix_clk,
  input  logic              edge_sel,
  input  logic [WORD_W-1:0] pix_data,
  output logic [WORD_W-1:0] hold_q,
  output logic              load_q
);
  logic [WORD_W-1:0] cap_rise, cap_fall;
  logic [2:0]        pclk_sync;
  logic              rise_det, fall_det, strobe;

  // Pixel-domain capture on both edges; the bit domain picks one.
  always_ff @(posedge pix_clk) cap_rise <= pix_data;
  always_ff @(negedge pix_clk) cap_fall <= pix_data;

  // Pixel clock sampled into the bit domain (pure pin sampling, no clear).
  always_ff @(posedge bit_clk) pclk_sync <= {pclk_sync[1:0], pix_clk};

  assign rise_det = pclk_sync[1] & ~pclk_sync[2];
  assign fall_det = ~pclk_sync[1] & pclk_sync[2];
  assign strobe   = edge_sel ? rise_det : fall_det;

  // First buffer stage: the hold register. load_q tells the shifters to copy it.
  always_ff @(posedge bit_clk) begin
    if (clr) begin
      hold_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= strobe;
      if (strobe) hold_q <= edge_sel ? cap_rise : cap_fall;
    end
  end

  assert_single_load_R3: assert property (@(posedge bit_clk) disable iff (clr)
    load_q |=> !load_q);
endmodule

// File: rtl/lvds7_lock.sv
module lvds7_lock #(
  parameter int LOCK_CYCLES = 100
) (
  input  logic bit_clk,
  input  logic run,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  assign locked = (cnt_q == LIMIT);

  always_ff @(posedge bit_clk) begin
    if (!run)        cnt_q <= '0;
    else if (!locked) cnt_q <= cnt_q + 1'b1;
  end

  assert_lock_cleared_R9: assert property (@(posedge bit_clk)
    !run |=> !locked);
endmodule

// File: rtl/lvds7_lanes.sv
module lvds7_lanes #(
  parameter int LANES = 3,
  parameter int SLOTS = 7
) (
  input  logic                     bit_clk,
  input  logic                     clr,
  input  logic                     load,
  input  logic                     gate_nx,
  input  logic [LANES*SLOTS-1:0]   word,
  output logic [LANES-1:0]         lane_q,
  output logic                     clk_lane_q,
  output logic [$clog2(SLOTS)-1:0] slot_q
);
  import lvds7_pkg::*;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_nx;

  assign slot_nx = load ? '0 : ((slot_q == LAST) ? '0 : slot_q + 1'b1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SLOTS-1:0] sh_q;
    logic             bit_q;
    always_ff @(posedge bit_clk) begin
      if (clr) begin
        sh_q  <= '0;
        bit_q <= 1'b0;
      end else if (load) begin
        sh_q  <= word[g*SLOTS +: SLOTS] >> 1;
        bit_q <= gate_nx & word[g*SLOTS];
      end else begin
        sh_q  <= sh_q >> 1;
        bit_q <= gate_nx & sh_q[0];
      end
    end
    assign lane_q[g] = bit_q;
  end

  always_ff @(posedge bit_clk) begin
    if (clr) begin
      slot_q     <= '0;
      clk_lane_q <= 1'b0;
    end else begin
      slot_q     <= slot_nx;
      clk_lane_q <= gate_nx & fwd_clk_level(int'(slot_nx), SLOTS);
    end
  end

  // Checker: cycles between consecutive loads.
  logic [SLOT_W:0] gap_q;
  logic            seen_q;
  always_ff @(posedge bit_clk) begin
    if (clr) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (load) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_load_period_R3: assert property (@(posedge bit_clk) disable iff (clr)
    (load && seen_q) |-> gap_q == (SLOT_W+1)'(SLOTS - 1));
endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer #(
  parameter int LANES       = 3,
  parameter int SLOTS       = 7,
  parameter int LOCK_CYCLES = 100
) (
  input  logic                   rst,
  input  logic                   bit_clk,
  input  logic                   pix_clk,
  input  logic [LANES*SLOTS-1:0] pix_data,
  input  logic                   edge_sel,
  input  logic                   pwr_dn_n,
  output logic [LANES-1:0]       lane_out,
  output logic                   clk_lane_out,
  output logic                   out_en
);
  localparam int WORD_W = LANES * SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);

  logic              run, clr, locked, load, oe_nx;
  logic [WORD_W-1:0] hold;
  logic [SLOT_W-1:0] slot;

  assign run   = ~rst & pwr_dn_n;
  assign clr   = ~run;
  assign oe_nx = run & (out_en | (locked & load));

  lvds7_capture #(.WORD_W(WORD_W)) u_capture (
    .bit_clk (bit_clk),
    .clr     (clr),
    .pix_clk (pix_clk),
    .edge_sel(edge_sel),
    .pix_data(pix_data),
    .hold_q  (hold),
    .load_q  (load)
  );

  lvds7_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .bit_clk(bit_clk),
    .run    (run),
    .locked (locked)
  );

  lvds7_lanes #(.LANES(LANES), .SLOTS(SLOTS)) u_lanes (
    .bit_clk   (bit_clk),
    .clr       (clr),
    .load      (load),
    .gate_nx   (oe_nx),
    .word      (hold),
    .lane_q    (lane_out),
    .clk_lane_q(clk_lane_out),
    .slot_q    (slot)
  );

  always_ff @(posedge bit_clk) begin
    if (clr) out_en <= 1'b0;
    else     out_en <= oe_nx;
  end

  assert_pd_quiet_R6: assert property (@(posedge bit_clk) disable iff (rst)
    !pwr_dn_n |=> (!out_en && lane_out == '0 && !clk_lane_out));

  assert_off_zero_R8: assert property (@(posedge bit_clk) disable iff (rst)
    !out_en |-> (lane_out == '0 && !clk_lane_out));

  assert_enable_at_boundary_R7: assert property (@(posedge bit_clk) disable iff (rst)
    $rose(out_en) |-> slot == '0);

  assert_fwd_fall_slot_R5: assert property (@(posedge bit_clk) disable iff (rst)
    (out_en && $past(out_en) && $fell(clk_lane_out)) |-> slot == SLOT_W'(2));
endmodule

// File: tb/test_lvds7_serializer.sv
module test_lvds7_serializer;
  localparam int LOCKB = 100;
  localparam int WW    = 21;

  logic          rst = 1'b1, bclk = 1'b0, pclk = 1'b0;
  logic [WW-1:0] din = '0;
  logic          edge_sel = 1'b0, pwr_dn_n = 1'b0;
  logic [2:0]    lane_out;
  logic          clk_lane_out, out_en;

  lvds7_serializer #(.LOCK_CYCLES(LOCKB)) i_lvds7_serializer (
    .rst(rst), .bit_clk(bclk), .pix_clk(pclk), .pix_data(din),
    .edge_sel(edge_sel), .pwr_dn_n(pwr_dn_n),
    .lane_out(lane_out), .clk_lane_out(clk_lane_out), .out_en(out_en)
  );

  initial forever #10 bclk = ~bclk;            // 50 MHz bit clock
  initial begin #5; forever #70 pclk = ~pclk; end  // 7x slower pixel clock

  int checks = 0, fails = 0, matched = 0;
  logic [WW-1:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Driver: word stable around the selected edge, complement around the other (R4).
  initial begin
    int unsigned i = 1;
    forever begin
      logic [WW-1:0] w;
      w = WW'(i * 32'h000A_5A93);
      i++;
      if (!edge_sel) begin
        @(posedge pclk); #2; din = w; expq.push_back(w);
        @(negedge pclk); #2; din = ~w;
      end else begin
        @(negedge pclk); #2; din = w; expq.push_back(w);
        @(posedge pclk); #2; din = ~w;
      end
    end
  end

  // Monitor: aligns on the clock lane's falling edge and rebuilds words.
  logic [3:0] hist [7];
  int  ph = -1;
  bit  prev_c = 0, first = 1;
  always @(negedge bclk) begin
    if (!rst && !out_en)
      chk(lane_out == 3'b0 && !clk_lane_out, "R8", "outputs while disabled",
          {clk_lane_out, lane_out}, 0);
    if (!out_en) begin
      ph = -1; prev_c = 0; first = 1;
    end else begin
      for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = {clk_lane_out, lane_out};
      if (ph < 0) begin
        if (prev_c && !clk_lane_out) ph = 2;
      end else ph = (ph == 6) ? 0 : ph + 1;
      prev_c = clk_lane_out;
      if (ph == 6) begin
        logic [WW-1:0] got;
        logic [6:0]    cpat;
        for (int s = 0; s < 7; s++) begin
          cpat[s] = hist[6-s][3];
          for (int l = 0; l < 3; l++) got[l*7+s] = hist[6-s][l];
        end
        chk(cpat == 7'b110_0011, "R5", "clock lane slots 6..0", cpat, 7'b110_0011);
        if (first) begin
          while (expq.size() > 0 && expq[0] != got) void'(expq.pop_front());
          first = 0;
        end
        if (expq.size() == 0) chk(0, "R1/R2/R4", "word not expected", got, 0);
        else begin
          logic [WW-1:0] e;
          e = expq.pop_front();
          chk(got == e, "R1/R2/R4", "serial word", got, e);
          if (got == e) matched++;
        end
      end
    end
  end

  task automatic release_and_time(output int n);
    @(negedge bclk); pwr_dn_n = 1'b1; n = 0;
    do begin @(negedge bclk); n++; end while (!out_en && n < LOCKB + 50);
  endtask

  task automatic power_down(input int hold_cycles);
    @(negedge bclk); pwr_dn_n = 1'b0;
    @(negedge bclk);
    chk(!out_en && lane_out == 3'b0 && !clk_lane_out, "R6", "one cycle after power-down",
        {out_en, clk_lane_out, lane_out}, 0);
    repeat (hold_cycles) @(negedge bclk);
  endtask

  initial begin
    repeat (150000) @(posedge bclk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int n, m0;
    // R10: reset state
    repeat (3) @(negedge bclk);
    chk(!out_en && lane_out == 3'b0 && !clk_lane_out, "R10", "during reset",
        {out_en, clk_lane_out, lane_out}, 0);
    rst = 1'b0;
    repeat (20) @(negedge bclk);
    chk(!out_en, "R6", "held in power-down", out_en, 0);

    // R7: lock interval after clean release, falling-edge capture
    release_and_time(n);
    chk(n >= LOCKB + 1 && n <= LOCKB + 7, "R7", "lock cycles", n, LOCKB + 1);
    m0 = matched;
    repeat (40 * 7) @(negedge bclk);
    chk(matched - m0 >= 35, "R3", "words per 7 cycles (falling edge)", matched - m0, 40);

    // R6: power-down quiets outputs; then switch to rising-edge capture
    power_down(10);
    edge_sel = 1'b1;
    repeat (30) @(negedge bclk);

    // R9: power-down in the middle of a lock restarts the interval
    @(negedge bclk); pwr_dn_n = 1'b1;
    repeat (LOCKB / 2) @(negedge bclk);
    chk(!out_en, "R9", "enable during partial lock", out_en, 0);
    power_down(3);
    release_and_time(n);
    chk(n >= LOCKB + 1 && n <= LOCKB + 7, "R9", "lock cycles after restart", n, LOCKB + 1);

    // R4: rising-edge capture stream
    m0 = matched;
    repeat (40 * 7) @(negedge bclk);
    chk(matched - m0 >= 35, "R4", "words matched with rising edge", matched - m0, 40);

    // R10: reset while running
    @(negedge bclk); rst = 1'b1;
    @(negedge bclk);
    chk(!out_en && lane_out == 3'b0 && !clk_lane_out, "R10", "reset while running",
        {out_en, clk_lane_out, lane_out}, 0);
    rst = 1'b0;
    repeat (5) @(negedge bclk);
    summary();
  end
endmodule